// File: doc/BRIEF.md
# Local Interrupt Timer with Prescaled Countdown

This block is the countdown timer of a per-core interrupt unit. Software loads a 32-bit start value, picks a clock prescale through a divide-configuration register and writes a timer entry that holds the interrupt vector, a mask bit and a mode bit. The counter then steps down once per prescaled tick. When it reaches zero it raises a one-cycle interrupt request carrying the vector, marked as edge triggered. In one-shot mode it stays at zero. In periodic mode the next tick reloads the start value.

The registers sit in a 4 KiB window at a 16-byte stride. The register index is address bits [11:4] and bits [3:0] are ignored. Reads are combinational on the address. Any access to an index this block does not own sets a sticky address-error flag, which only reset clears. The prescaler runs freely and is cleared by every write of the start value, so the first tick lands a fixed number of clocks after that write.

Top module: `lapic_timer`

## Requirements
- R1: After reset the start value, current count and divide register read 0, the timer entry reads 0x0001_0000 (masked, one-shot, vector 0), addr_err_o is 0 and irq_req_o is 0.
- R2: A write to the divide register (index 0x3E) keeps only the bits in mask 0xB. A read returns the kept bits.
- R3: With idx = {div[3], div[1:0]}, the prescale shift is s = (idx + 1) mod 8, so idx 7 divides by 1. In one-shot mode, k clock edges after the start-value write (index 0x38) loads N, the current count (index 0x39) reads max(N - floor(k / 2^s), 0).
- R4: Timer-entry bit 17 set selects periodic mode. The count then reads N - (floor(k / 2^s) mod (N + 1)).
- R5: On the edge where a tick moves the count from 1 to 0, irq_req_o goes high for exactly one cycle. In that cycle irq_vec_o holds timer-entry bits [7:0] and irq_level_o is 0 (edge).
- R6: If timer-entry bit 16 (mask) is set, no request is raised on expiry. The count still runs.
- R7: A start value of 0 leaves the timer disarmed. The count stays 0 and no request is raised, in either mode.
- R8: A timer-entry write takes effect on the next tick. A one-shot timer parked at 0 that is switched to periodic reloads N on the next tick.
- R9: A write to the current-count index is ignored. It does not change the count and does not set addr_err_o.
- R10: A read or a write of any index other than 0x32, 0x38, 0x39 and 0x3E sets addr_err_o, which stays set until reset. Such reads return 0.
- R11: A start-value write on the same edge as an expiring tick wins. The new value is loaded and no request is raised for that edge.
- R12: Rewriting the start value during a countdown restarts the count and the prescaler from that write.
- R13: The timer entry (index 0x32) stores only bits 17, 16 and [7:0]. Its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (used for error detection) |
| addr_i | input | 12 | Byte address; bits [11:4] select the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| addr_err_o | output | 1 | Sticky illegal-address flag |
| irq_req_o | output | 1 | One-cycle interrupt request on expiry |
| irq_vec_o | output | 8 | Vector of the request |
| irq_level_o | output | 1 | Trigger mode of the request, 0 = edge |

## Verification
The delicate case is a software reload of the start value on the same edge that the counter makes its final 1-to-0 step. Both want to update the current count and one of them wants to raise a request. The bench starts a divide-by-1 countdown of 3 and then times a start-value write onto exactly the third edge after it. The bench judges the result by checking that no request appears in the following cycle and that the count reads the new value. It then checks that the new countdown itself expires with a request on the predicted edge.

// File: rtl/lapic_timer_pkg.sv
package lapic_timer_pkg;
  localparam int IDX_LSB = 4;
  localparam int IDX_W   = 8;
  localparam int ADDR_W  = IDX_LSB + IDX_W;
  localparam int SHIFT_W = 3;
  localparam int VEC_W   = 8;
  localparam int DIV_W   = 4;

  localparam logic [IDX_W-1:0] IDX_ENTRY = 8'h32;
  localparam logic [IDX_W-1:0] IDX_INIT  = 8'h38;
  localparam logic [IDX_W-1:0] IDX_CUR   = 8'h39;
  localparam logic [IDX_W-1:0] IDX_DIV   = 8'h3E;

  localparam logic [DIV_W-1:0] DIV_KEEP = 4'hB;
  localparam int ENT_MASK_BIT = 16;
  localparam int ENT_PER_BIT  = 17;
  localparam logic TRIG_EDGE  = 1'b0;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } entry_t;

  typedef enum logic [2:0] {
    SEL_ENTRY, SEL_INIT, SEL_CUR, SEL_DIV, SEL_BAD
  } sel_e;

  // shift = ({d3,d1,d0} + 1) mod 8
  function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] d);
    logic [SHIFT_W-1:0] idx;
    idx = {d[3], d[1:0]};
    return idx + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/lt_regs.sv
module lt_regs
  import lapic_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic [CNT_W-1:0]   cur_i,
  output logic [CNT_W-1:0]   rdata_o,
  output logic               addr_err_o,
  output logic               load_o,
  output logic [CNT_W-1:0]   init_o,
  output logic [SHIFT_W-1:0] shift_o,
  output entry_t             entry_o
);
  logic [IDX_W-1:0] idx;
  sel_e             sel;
  logic [CNT_W-1:0] init_q;
  logic [DIV_W-1:0] div_q;
  entry_t           entry_q;
  logic             err_q;

  assign idx = addr_i[ADDR_W-1:IDX_LSB];

  always_comb begin
    unique case (idx)
      IDX_ENTRY: sel = SEL_ENTRY;
      IDX_INIT:  sel = SEL_INIT;
      IDX_CUR:   sel = SEL_CUR;
      IDX_DIV:   sel = SEL_DIV;
      default:   sel = SEL_BAD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= '0;
      div_q   <= '0;
      entry_q <= '{periodic: 1'b0, masked: 1'b1, vector: '0};
      err_q   <= 1'b0;
    end else begin
      if (wr_en_i) begin
        unique case (sel)
          SEL_ENTRY: entry_q <= '{periodic: wdata_i[ENT_PER_BIT],
                                  masked:   wdata_i[ENT_MASK_BIT],
                                  vector:   wdata_i[VEC_W-1:0]};
          SEL_INIT:  init_q  <= wdata_i;
          SEL_DIV:   div_q   <= wdata_i[DIV_W-1:0] & DIV_KEEP;
          SEL_CUR:   ;  // read-only
          default:   err_q   <= 1'b1;
        endcase
      end
      if (rd_en_i && sel == SEL_BAD) err_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_ENTRY: begin
        rdata_o[VEC_W-1:0]   = entry_q.vector;
        rdata_o[ENT_MASK_BIT] = entry_q.masked;
        rdata_o[ENT_PER_BIT]  = entry_q.periodic;
      end
      SEL_INIT: rdata_o = init_q;
      SEL_CUR:  rdata_o = cur_i;
      SEL_DIV:  rdata_o[DIV_W-1:0] = div_q;
      default:  rdata_o = '0;
    endcase
  end

  assign load_o     = wr_en_i && (sel == SEL_INIT);
  assign init_o     = init_q;
  assign shift_o    = div_to_shift(div_q);
  assign entry_o    = entry_q;
  assign addr_err_o = err_q;
endmodule

// File: rtl/lt_prescaler.sv
module lt_prescaler
  import lapic_timer_pkg::*;
#(
  parameter int SH_W = SHIFT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic [SH_W-1:0] shift_i,
  output logic            tick_o
);
  localparam int PRE_W = (1 << SH_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] low_mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) low_mask[i] = (i < int'(shift_i));
  end

  // tick when the low 'shift' bits are all ones: one tick per 2^shift clocks
  assign tick_o = &(pre_q | ~low_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clear_i) pre_q <= '0;
    else              pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/lt_counter.sv
module lt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cur_q;
  logic             at_zero;

  assign at_zero  = (cur_q == '0);
  assign expire_o = tick_i && !load_i && (cur_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
    end else if (load_i) begin
      cur_q <= load_val_i;
    end else if (tick_i) begin
      if (!at_zero)        cur_q <= cur_q - CNT_W'(1);
      else if (periodic_i) cur_q <= reload_i;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/lapic_timer.sv
module lapic_timer
  import lapic_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              addr_err_o,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic              irq_level_o
);
  logic [CNT_W-1:0]   cur_q;
  logic [CNT_W-1:0]   init_val;
  logic [SHIFT_W-1:0] shift;
  entry_t             entry;
  logic               load;
  logic               tick;
  logic               expire;
  logic               entry_masked;
  logic               entry_periodic;
  logic               req_q;
  logic [VEC_W-1:0]   vec_q;

  lt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
    .cur_i(cur_q), .rdata_o, .addr_err_o,
    .load_o(load), .init_o(init_val), .shift_o(shift), .entry_o(entry)
  );

  lt_prescaler #(.SH_W(SHIFT_W)) u_pre (
    .clk_i, .rst_ni, .clear_i(load), .shift_i(shift), .tick_o(tick)
  );

  assign entry_masked   = entry.masked;
  assign entry_periodic = entry.periodic;

  lt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(wdata_i), .tick_i(tick),
    .periodic_i(entry_periodic), .reload_i(init_val),
    .cur_o(cur_q), .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      vec_q <= '0;
    end else begin
      req_q <= expire && !entry_masked;
      if (expire) vec_q <= entry.vector;
    end
  end

  assign irq_req_o   = req_q;
  assign irq_vec_o   = vec_q;
  assign irq_level_o = TRIG_EDGE;
endmodule

// File: rtl/lapic_timer_chk.sv
module lapic_timer_chk
  import lapic_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wdata,
  input logic [CNT_W-1:0]  cur,
  input logic [CNT_W-1:0]  init,
  input logic              tick,
  input logic              periodic,
  input logic              masked,
  input logic              irq_req,
  input logic              addr_err
);
  logic [IDX_W-1:0] idx;
  logic             ld;
  assign idx = addr[ADDR_W-1:IDX_LSB];
  assign ld  = wr_en && (idx == IDX_INIT);

  assert_oneshot_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!periodic && cur == '0 && !ld) |=> cur == '0);

  assert_irq_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> cur == '0);

  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !$past(masked));

  assert_zero_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (init == '0 && cur == '0) |=> !irq_req);

  assert_periodic_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && periodic && cur == '0 && !ld) |=> cur == $past(init));

  assert_cur_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_CUR && !addr_err) |=> !addr_err);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> addr_err);

  assert_load_no_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> !irq_req);

  assert_load_value_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cur == $past(wdata));
endmodule

bind lapic_timer lapic_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
  .cur(cur_q), .init(init_val), .tick(tick), .periodic(entry_periodic),
  .masked(entry_masked), .irq_req(irq_req_o), .addr_err(addr_err_o)
);

// File: tb/lapic_timer_test.sv
module lapic_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_ENT = 12'h320, A_INIT = 12'h380, A_CUR = 12'h390, A_DIV = 12'h3E0;
  localparam int NV = 8;
  // {div[3:0], periodic, init[15:0], edges k[15:0], expected count[15:0]}
  localparam logic [52:0] VEC [NV] = '{
    {4'hB, 1'b0, 16'd10,  16'd4,   16'd6},
    {4'h0, 1'b0, 16'd10,  16'd7,   16'd7},
    {4'h1, 1'b0, 16'd5,   16'd30,  16'd0},
    {4'h8, 1'b0, 16'd100, 16'd70,  16'd98},
    {4'hB, 1'b1, 16'd3,   16'd9,   16'd2},
    {4'h0, 1'b1, 16'd4,   16'd23,  16'd3},
    {4'hA, 1'b0, 16'd7,   16'd300, 16'd5},
    {4'hB, 1'b1, 16'd2,   16'd3,   16'd2}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        addr_err_o, irq_req_o, irq_level_o;
  logic [7:0]  irq_vec_o;
  int total = 0, bad = 0;

  lapic_timer uut (.clk_i(clk), .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i,
                   .rdata_o, .addr_err_o, .irq_req_o, .irq_vec_o, .irq_level_o);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic arm(input logic [3:0] dv, input logic [31:0] ent, input logic [31:0] n);
    wr(A_INIT, 32'd0);
    wr(A_DIV, {28'd0, dv});
    wr(A_ENT, ent);
    wr(A_INIT, n);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int irqs;
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    // R1 reset state
    peek(A_ENT, d);  chk("R1 entry", d, 32'h0001_0000);
    peek(A_INIT, d); chk("R1 init", d, 0);
    peek(A_CUR, d);  chk("R1 cur", d, 0);
    peek(A_DIV, d);  chk("R1 div", d, 0);
    chk("R1 err", addr_err_o, 0);
    chk("R1 irq", irq_req_o, 0);

    // R2 divide mask, R13 entry fields
    wr(A_DIV, 32'hFFFF_FFFF); peek(A_DIV, d); chk("R2 div keep", d, 32'hB);
    wr(A_DIV, 32'h0000_0004); peek(A_DIV, d); chk("R2 div drop", d, 32'h0);
    wr(A_ENT, 32'hFFFF_FFFF); peek(A_ENT, d); chk("R13 entry", d, 32'h0003_00FF);

    // R3/R4 vector table
    for (int i = 0; i < NV; i++) begin
      logic [52:0] v;
      v = VEC[i];
      arm(v[52:49], {14'd0, v[48], 1'b1, 16'd0}, {16'd0, v[47:32]});
      cyc(int'(v[31:16]));
      peek(A_CUR, d);
      chk(v[48] ? "R4 periodic count" : "R3 oneshot count", d, {16'd0, v[15:0]});
    end

    // R5 expiry request
    arm(4'hB, 32'h0000_005A, 3);
    cyc(2);
    chk("R5 no early irq", irq_req_o, 0);
    peek(A_CUR, d); chk("R5 count before", d, 1);
    cyc(1);
    chk("R5 irq", irq_req_o, 1);
    chk("R5 vec", irq_vec_o, 8'h5A);
    chk("R5 level", irq_level_o, 0);
    peek(A_CUR, d); chk("R5 count zero", d, 0);
    cyc(1);
    chk("R5 one cycle", irq_req_o, 0);

    // R6 masked
    arm(4'hB, 32'h0001_005A, 3);
    irqs = 0;
    for (int i = 0; i < 6; i++) begin cyc(1); if (irq_req_o) irqs++; end
    chk("R6 masked irqs", irqs, 0);
    peek(A_CUR, d); chk("R6 count ran", d, 0);

    // R7 zero start value, periodic
    arm(4'hB, 32'h0002_005A, 0);
    irqs = 0;
    for (int i = 0; i < 20; i++) begin cyc(1); if (irq_req_o) irqs++; end
    chk("R7 no irq", irqs, 0);
    peek(A_CUR, d); chk("R7 count", d, 0);

    // R8 switch to periodic after one-shot expiry
    arm(4'hB, 32'h0000_005A, 2);
    cyc(4);
    wr(A_ENT, 32'h0002_005A);
    peek(A_CUR, d); chk("R8 still zero", d, 0);
    cyc(1);
    peek(A_CUR, d); chk("R8 reload", d, 2);

    // R11 start-value write on the expiring edge
    arm(4'hB, 32'h0000_005A, 3);
    cyc(2);
    wr(A_INIT, 5);
    chk("R11 no irq", irq_req_o, 0);
    peek(A_CUR, d); chk("R11 new count", d, 5);
    cyc(5);
    chk("R11 later irq", irq_req_o, 1);

    // R12 restart mid-count with divide by 4
    arm(4'h1, 32'h0001_0000, 100);
    cyc(9);
    wr(A_INIT, 20);
    cyc(3); peek(A_CUR, d); chk("R12 before tick", d, 20);
    cyc(1); peek(A_CUR, d); chk("R12 first tick", d, 19);

    // R9 current-count write ignored
    arm(4'hB, 32'h0001_0000, 50);
    wr(A_CUR, 32'd0);
    peek(A_CUR, d); chk("R9 count", d, 49);
    chk("R9 err", addr_err_o, 0);

    // R10 unknown read
    addr_i = 12'h400; rd_en_i = 1'b1; #1;
    chk("R10 read data", rdata_o, 0);
    @(posedge clk); @(negedge clk); rd_en_i = 1'b0;
    chk("R10 read err", addr_err_o, 1);
    cyc(2);
    chk("R10 sticky", addr_err_o, 1);

    // R10 unknown write after fresh reset
    rst_ni = 1'b0; cyc(2); rst_ni = 1'b1; cyc(1);
    chk("R1 err cleared", addr_err_o, 0);
    wr(12'h500, 32'h1234);
    chk("R10 write err", addr_err_o, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule